// File: doc/BRIEF.md
# Single-Channel Memory/Peripheral Word Mover

This block is one channel of a word-moving engine. It carries 32-bit words between a peripheral-side address and a memory-side address. Software programs it through a small register file. That file holds a control word, a status word, a pointer and a sequence word for each side. Setting the run bit starts a transfer.

For each word the channel raises `xfer_valid` together with both current addresses. The surrounding fabric completes the word by asserting `xfer_ack` in the same cycle. With flow control selected, the channel only offers a word while the chosen peripheral request line is high. Three modes are supported:

- **Single-shot**: stops after the programmed number of words.
- **Single-buffer repeating**: reloads pointers and count at every end-of-count.
- **Ping-pong**: splits the buffer into two halves, signals each half, and takes new settings only once both halves are done.

Both pointers can be confined to power-of-two wrap windows. A global enable input freezes every transfer so that the remaining count can be read while it is not moving.

Top module: `dma_chan_engine`

## Requirements
- R1: Register map (3-bit `reg_addr`): 0 = control, 1 = status, 4 = memory pointer, 5 = memory sequence, 6 = peripheral pointer, 7 = peripheral sequence. Control and sequence words read back as written. Control bits 26:22 and 1:0 read as zero. Pointers ignore the two low address bits and read them as zero.
- R2: Control bit 31 is run, bit 27 is single-shot, and bits 15:2 hold the word count minus one. In single-shot mode exactly count+1 words are transferred. Then status bit 31 (busy) and control bit 31 read zero.
- R3: Status bit 30 (end-of-count) becomes set at every end-of-count and is cleared only by writing status with bit 30 set. `irq` equals that bit ANDed with control bit 30.
- R4: Without single-shot or ping-pong, each end-of-count reloads the count from the control count field and both pointers from their last written values, and the channel keeps running. A count written while running does not change the remaining count (status bits 15:2) until that boundary.
- R5: While `glb_en` is low, or control bit 29 (hold) is set, no word is offered. The remaining count stays fixed and status bit 29 (halt) reads one while running. Releasing the pause resumes the transfer and completes the full count.
- R6: Memory sequence bit 19 selects ping-pong mode. Each half ends with end-of-count and a toggle of status bit 28. Pointers written while running, and a new count, take effect only after the second half.
- R7: Memory sequence bits 18:16 select a memory-pointer wrap window of none, 32, 64, 128, 256, 512, 1024 or 2048 words (codes 0..7). The pointer returns to the window's aligned base after its last word.
- R8: Peripheral sequence bits 18:16 select a peripheral wrap window of none, 1, 2, 4, 8, 16, 32 or 64 words. A one-word window keeps the peripheral address fixed.
- R9: With control bit 21 (flow) set, a word is offered only while `dev_req[sel]` is high, where sel is control bits 20:16. Other request lines have no effect.
- R10: `mem_burst` reports the burst length from memory sequence bits 26:24: code 5 gives 4, code 6 gives 8, and any other code gives 1.
- R11: After reset all registers read zero, and `xfer_valid` and `irq` are low.
- R12: `xfer_to_per` follows control bit 28: 1 means memory to peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable; low freezes the channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dev_req | input | 32 | Peripheral request lines |
| xfer_valid | output | 1 | A word is offered this cycle |
| xfer_ack | input | 1 | Fabric completes the offered word |
| xfer_to_per | output | 1 | Transfer direction, 1 = memory to peripheral |
| mem_addr | output | ADDR_W | Current memory-side byte address |
| per_addr | output | ADDR_W | Current peripheral-side byte address |
| mem_burst | output | 4 | Memory burst length in words |
| irq | output | 1 | End-of-count interrupt |

## Verification
The properties assume that `xfer_ack` only means something while `xfer_valid` is high. They also assume that software never writes a register in the same cycle as the final word of a count, because such a write would override the reload. The stimulus follows both rules:

- Register writes are made either while the channel is idle, while it is paused, or while `xfer_ack` is held low.
- Words are released by pulsing `xfer_ack` for a known number of cycles.
- All inputs change only on the falling clock edge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int REG_W  = 32;
    localparam int CNT_W  = 14;
    localparam int SEL_W  = 5;
    localparam int WRAP_W = 3;
    localparam int NREQ   = 1 << SEL_W;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_STAT = 3'd1,
        RA_MPTR = 3'd4,
        RA_MSEQ = 3'd5,
        RA_PPTR = 3'd6,
        RA_PSEQ = 3'd7
    } reg_sel_e;

    localparam int B_RUN   = 31;
    localparam int B_IE    = 30;
    localparam int B_HOLD  = 29;
    localparam int B_DIR   = 28;
    localparam int B_ONCE  = 27;
    localparam int B_FLOW  = 21;
    localparam int B_SEL   = 16;
    localparam int B_CNT   = 2;
    localparam int B_DBL   = 19;
    localparam int B_WRAP  = 16;
    localparam int B_BURST = 24;
endpackage

// File: rtl/dma_ptr_step.sv
module dma_ptr_step #(
    parameter int PW      = 30,
    parameter int WIN_OFS = 4
) (
    input  logic [PW-1:0]                    ptr,
    input  logic [dma_chan_pkg::WRAP_W-1:0]  wrap,
    output logic [PW-1:0]                    nxt
);
    logic [PW-1:0] mask;

    always_comb begin
        if (wrap == '0) begin
            mask = '1;
        end else begin
            mask = (PW'(1) << (int'(wrap) + WIN_OFS)) - PW'(1);
        end
        nxt = (ptr & ~mask) | ((ptr + PW'(1)) & mask);
    end
endmodule

// File: rtl/dma_flow_gate.sv
module dma_flow_gate (
    input  logic [dma_chan_pkg::NREQ-1:0]  dev_req,
    input  logic [dma_chan_pkg::SEL_W-1:0] sel,
    input  logic                           flow_en,
    output logic                           ok
);
    assign ok = !flow_en || dev_req[sel];
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NREQ-1:0]   dev_req,
    output logic              xfer_valid,
    input  logic              xfer_ack,
    output logic              xfer_to_per,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] per_addr,
    output logic [3:0]        mem_burst,
    output logic              irq
);
    localparam int PW = ADDR_W - 2;

    typedef struct packed {
        logic             run;
        logic             ie;
        logic             hold;
        logic             dir;
        logic             once;
        logic             flow;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic             eoc;
        logic             pp;
        logic [PW-1:0]    mem_prog;
        logic [PW-1:0]    mem_cur;
        logic [PW-1:0]    per_prog;
        logic [PW-1:0]    per_cur;
        logic [REG_W-1:0] mseq;
        logic [REG_W-1:0] pseq;
    } chan_st_t;

    chan_st_t      state_d, state_q;
    logic [PW-1:0] mem_nxt, per_nxt;
    logic          gate_ok, pause, fire, last;

    dma_ptr_step #(.PW(PW), .WIN_OFS(4)) i_mem_step (
        .ptr (state_q.mem_cur),
        .wrap(state_q.mseq[B_WRAP +: WRAP_W]),
        .nxt (mem_nxt)
    );

    dma_ptr_step #(.PW(PW), .WIN_OFS(-1)) i_per_step (
        .ptr (state_q.per_cur),
        .wrap(state_q.pseq[B_WRAP +: WRAP_W]),
        .nxt (per_nxt)
    );

    dma_flow_gate i_gate (
        .dev_req(dev_req),
        .sel    (state_q.sel),
        .flow_en(state_q.flow),
        .ok     (gate_ok)
    );

    assign pause       = !glb_en || state_q.hold;
    assign xfer_valid  = state_q.run && !pause && gate_ok;
    assign fire        = xfer_valid && xfer_ack;
    assign last        = (state_q.cnt == '0);
    assign xfer_to_per = state_q.dir;
    assign irq         = state_q.eoc && state_q.ie;
    assign mem_addr    = {state_q.mem_cur, 2'b00};
    assign per_addr    = {state_q.per_cur, 2'b00};

    always_comb begin
        case (state_q.mseq[B_BURST +: 3])
            3'd5:    mem_burst = 4'd4;
            3'd6:    mem_burst = 4'd8;
            default: mem_burst = 4'd1;
        endcase
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {state_q.run, state_q.ie, state_q.hold, state_q.dir,
                                  state_q.once, 5'b0, state_q.flow, state_q.sel,
                                  state_q.shadow, 2'b00};
            RA_STAT: reg_rdata = {state_q.run, state_q.eoc, state_q.run && pause,
                                  state_q.pp, 12'b0, state_q.cnt, 2'b00};
            RA_MPTR: reg_rdata = REG_W'({state_q.mem_cur, 2'b00});
            RA_MSEQ: reg_rdata = state_q.mseq;
            RA_PPTR: reg_rdata = REG_W'({state_q.per_cur, 2'b00});
            RA_PSEQ: reg_rdata = state_q.pseq;
            default: reg_rdata = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;

        if (fire) begin
            if (!last) begin
                state_d.cnt     = state_q.cnt - CNT_W'(1);
                state_d.mem_cur = mem_nxt;
                state_d.per_cur = per_nxt;
            end else begin
                state_d.eoc = 1'b1;
                if (state_q.once) begin
                    state_d.run     = 1'b0;
                    state_d.mem_cur = mem_nxt;
                    state_d.per_cur = per_nxt;
                end else if (state_q.mseq[B_DBL] && !state_q.pp) begin
                    state_d.pp      = 1'b1;
                    state_d.cnt     = state_q.len;
                    state_d.mem_cur = mem_nxt;
                    state_d.per_cur = per_nxt;
                end else begin
                    state_d.pp      = 1'b0;
                    state_d.cnt     = state_q.shadow;
                    state_d.len     = state_q.shadow;
                    state_d.mem_cur = state_q.mem_prog;
                    state_d.per_cur = state_q.per_prog;
                end
            end
        end

        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    state_d.ie     = reg_wdata[B_IE];
                    state_d.hold   = reg_wdata[B_HOLD];
                    state_d.dir    = reg_wdata[B_DIR];
                    state_d.once   = reg_wdata[B_ONCE];
                    state_d.flow   = reg_wdata[B_FLOW];
                    state_d.sel    = reg_wdata[B_SEL +: SEL_W];
                    state_d.shadow = reg_wdata[B_CNT +: CNT_W];
                    if (!reg_wdata[B_RUN]) begin
                        state_d.run = 1'b0;
                    end else if (!state_q.run) begin
                        state_d.run     = 1'b1;
                        state_d.cnt     = reg_wdata[B_CNT +: CNT_W];
                        state_d.len     = reg_wdata[B_CNT +: CNT_W];
                        state_d.pp      = 1'b0;
                        state_d.mem_cur = state_q.mem_prog;
                        state_d.per_cur = state_q.per_prog;
                    end
                end
                RA_STAT: begin
                    if (reg_wdata[B_IE] && !(fire && last)) begin
                        state_d.eoc = 1'b0;
                    end
                end
                RA_MPTR: begin
                    state_d.mem_prog = reg_wdata[ADDR_W-1:2];
                    if (!state_q.run) state_d.mem_cur = reg_wdata[ADDR_W-1:2];
                end
                RA_PPTR: begin
                    state_d.per_prog = reg_wdata[ADDR_W-1:2];
                    if (!state_q.run) state_d.per_cur = reg_wdata[ADDR_W-1:2];
                end
                RA_MSEQ: state_d.mseq = reg_wdata;
                RA_PSEQ: state_d.pseq = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker
    import dma_chan_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic             reg_wr,
    input logic             xfer_valid,
    input logic             xfer_ack,
    input logic             busy,
    input logic             once,
    input logic             flow,
    input logic [SEL_W-1:0] sel,
    input logic [NREQ-1:0]  dev_req,
    input logic [CNT_W-1:0] rem,
    input logic             eoc
);
    logic fire, last;
    assign fire = xfer_valid && xfer_ack;
    assign last = (rem == '0);

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !xfer_valid);

    p_count_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !reg_wr) |=> $stable(rem));

    p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && once && last && !reg_wr) |=> !busy);

    p_eoc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> eoc);

    p_flow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && flow) |-> dev_req[sel]);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last && !reg_wr) |=> (rem == $past(rem) - CNT_W'(1)));
endmodule

bind dma_chan_engine dma_chan_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .reg_wr    (reg_wr),
    .xfer_valid(xfer_valid),
    .xfer_ack  (xfer_ack),
    .busy      (state_q.run),
    .once      (state_q.once),
    .flow      (state_q.flow),
    .sel       (state_q.sel),
    .dev_req   (dev_req),
    .rem       (state_q.cnt),
    .eoc       (state_q.eoc)
);

// File: tb/test_dma_chan_engine.sv
`timescale 1ns/1ps
module test_dma_chan_engine;
    localparam int ADDR_W = 32;
    localparam int WDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] dev_req = '0;
    logic        xfer_valid;
    logic        xfer_ack = 1'b0;
    logic        xfer_to_per;
    logic [31:0] mem_addr, per_addr;
    logic [3:0]  mem_burst;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int fires = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_chan_engine #(.ADDR_W(ADDR_W)) i_dma_chan_engine (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dev_req(dev_req),
        .xfer_valid(xfer_valid), .xfer_ack(xfer_ack),
        .xfer_to_per(xfer_to_per), .mem_addr(mem_addr), .per_addr(per_addr),
        .mem_burst(mem_burst), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst_n && xfer_valid && xfer_ack) fires <= fires + 1;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG && !done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles, expected under %0d", cycles, WDOG);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_ack(input int n);
        @(negedge clk);
        xfer_ack = 1'b1;
        repeat (n) @(negedge clk);
        xfer_ack = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd1, s);
            if (!s[31]) break;
        end
    endtask

    // {wrap[2:0], start byte address, words, expected final memory pointer}
    localparam logic [74:0] WRAP_TBL [0:4] = '{
        {3'd0, 32'h0000_1000, 8'd4, 32'h0000_1010},
        {3'd1, 32'h0000_1078, 8'd4, 32'h0000_1008},
        {3'd2, 32'h0000_20F8, 8'd3, 32'h0000_2004},
        {3'd7, 32'h0000_5FFC, 8'd2, 32'h0000_4004},
        {3'd0, 32'h0000_3003, 8'd1, 32'h0000_3004}
    };

    initial begin
        logic [31:0] v, v2;
        int f0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        rd(3'd0, v); chk("R11 ctrl", v, 32'h0);
        rd(3'd1, v); chk("R11 stat", v, 32'h0);
        rd(3'd4, v); chk("R11 mptr", v, 32'h0);
        chk("R11 valid", {31'b0, xfer_valid}, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);

        // R1: readback
        wr(3'd0, 32'h582D_0028); rd(3'd0, v); chk("R1 ctrl", v, 32'h582D_0028);
        wr(3'd0, 32'h07C0_0003); rd(3'd0, v); chk("R1 ctrl reserved", v, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R1 mseq", v, 32'hFFFF_FFFF);
        wr(3'd4, 32'h1234_5677); rd(3'd4, v); chk("R1 mptr", v, 32'h1234_5674);
        wr(3'd7, 32'h0003_0000); rd(3'd7, v); chk("R1 pseq", v, 32'h0003_0000);

        // R10: burst decode
        wr(3'd5, 32'h0500_0000); #1 chk("R10 burst4", {28'b0, mem_burst}, 32'd4);
        wr(3'd5, 32'h0600_0000); #1 chk("R10 burst8", {28'b0, mem_burst}, 32'd8);
        wr(3'd5, 32'h0400_0000); #1 chk("R10 burst1", {28'b0, mem_burst}, 32'd1);
        wr(3'd5, 32'h0700_0000); #1 chk("R10 burst other", {28'b0, mem_burst}, 32'd1);

        // R12: direction
        wr(3'd0, 32'h1000_0000); #1 chk("R12 to_per", {31'b0, xfer_to_per}, 32'd1);
        wr(3'd0, 32'h0000_0000); #1 chk("R12 to_mem", {31'b0, xfer_to_per}, 32'd0);

        // R7: memory wrap table
        wr(3'd7, 32'h0);
        for (int k = 0; k < 5; k++) begin
            logic [74:0] e;
            e = WRAP_TBL[k];
            wr(3'd5, {13'b0, e[74:72], 16'b0});
            wr(3'd4, e[71:40]);
            f0 = fires;
            wr(3'd0, 32'h8800_0000 | ({24'b0, e[39:32]} - 32'd1) << 2);
            xfer_ack = 1'b1;
            wait_idle();
            xfer_ack = 1'b0;
            rd(3'd4, v);
            chk($sformatf("R7 wrap entry %0d ptr", k), v, e[31:0]);
            chk($sformatf("R2 entry %0d words", k), fires - f0, {24'b0, e[39:32]});
        end
        wr(3'd5, 32'h0);

        // R2 + R3: single-shot with interrupt
        wr(3'd1, 32'h4000_0000);
        f0 = fires;
        wr(3'd0, 32'hC800_0014);
        xfer_ack = 1'b1; wait_idle(); xfer_ack = 1'b0;
        chk("R2 words", fires - f0, 32'd6);
        rd(3'd1, v); chk("R2 stat done", v, 32'h4000_0000);
        rd(3'd0, v); chk("R2 run clear", {31'b0, v[31]}, 32'd0);
        chk("R3 irq set", {31'b0, irq}, 32'd1);
        wr(3'd1, 32'hBFFF_FFFF); rd(3'd1, v); chk("R3 write zero keeps", v, 32'h4000_0000);
        wr(3'd1, 32'h4000_0000); rd(3'd1, v); chk("R3 w1c", v, 32'h0);
        chk("R3 irq clear", {31'b0, irq}, 32'd0);
        wr(3'd0, 32'h8800_0004);
        xfer_ack = 1'b1; wait_idle(); xfer_ack = 1'b0;
        rd(3'd1, v); chk("R3 eoc no ie", v, 32'h4000_0000);
        chk("R3 irq masked", {31'b0, irq}, 32'd0);
        wr(3'd1, 32'h4000_0000);

        // R9: flow control on request line 3
        dev_req = 32'hFFFF_FFF7;
        f0 = fires;
        wr(3'd0, 32'h8823_0008);
        xfer_ack = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 blocked", fires - f0, 32'd0);
        dev_req[3] = 1'b1;
        wait_idle(); xfer_ack = 1'b0;
        chk("R9 released", fires - f0, 32'd3);
        dev_req = '0;
        wr(3'd1, 32'h4000_0000);

        // R5: global enable pause
        f0 = fires;
        wr(3'd0, 32'h8800_018C);
        xfer_ack = 1'b1;
        repeat (10) @(negedge clk);
        glb_en = 1'b0;
        rd(3'd1, v);
        repeat (10) @(negedge clk);
        rd(3'd1, v2);
        chk("R5 count held", v2, v);
        chk("R5 halt", {31'b0, v2[29]}, 32'd1);
        chk("R5 no valid", {31'b0, xfer_valid}, 32'd0);
        glb_en = 1'b1;
        wait_idle(); xfer_ack = 1'b0;
        chk("R5 resume total", fires - f0, 32'd100);
        // R5: hold bit pause
        f0 = fires;
        wr(3'd0, 32'hA800_0024);
        xfer_ack = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 hold none", fires - f0, 32'd0);
        rd(3'd1, v); chk("R5 hold stat", v, 32'hE000_0024);
        wr(3'd0, 32'h8800_0024);
        wait_idle(); xfer_ack = 1'b0;
        chk("R5 hold total", fires - f0, 32'd10);
        wr(3'd1, 32'h4000_0000);

        // R4: repeating single buffer
        wr(3'd4, 32'h0000_0100);
        wr(3'd0, 32'h8000_000C);
        pulse_ack(2);
        rd(3'd1, v); chk("R4 mid count", v, 32'h8000_0004);
        wr(3'd0, 32'h8000_0004);
        rd(3'd1, v); chk("R4 shadow only", v, 32'h8000_0004);
        pulse_ack(2);
        rd(3'd1, v); chk("R4 reload count", v, 32'hC000_0004);
        rd(3'd4, v); chk("R4 reload ptr", v, 32'h0000_0100);
        pulse_ack(1);
        rd(3'd4, v); chk("R4 step ptr", v, 32'h0000_0104);
        pulse_ack(1);
        rd(3'd1, v); chk("R4 still running", v, 32'hC000_0004);
        wr(3'd0, 32'h0);
        rd(3'd1, v); chk("R4 stopped", {31'b0, v[31]}, 32'd0);
        wr(3'd1, 32'h4000_0000);

        // R6: ping-pong
        wr(3'd5, 32'h0008_0000);
        wr(3'd4, 32'h0000_0200);
        wr(3'd0, 32'hC000_0004);
        pulse_ack(2);
        rd(3'd1, v); chk("R6 first half", v, 32'hD000_0004);
        chk("R6 irq half", {31'b0, irq}, 32'd1);
        rd(3'd4, v); chk("R6 ptr continues", v, 32'h0000_0208);
        wr(3'd1, 32'h4000_0000);
        wr(3'd4, 32'h0000_0400);
        wr(3'd0, 32'hC000_0008);
        rd(3'd4, v); chk("R6 ptr deferred", v, 32'h0000_0208);
        pulse_ack(2);
        rd(3'd1, v); chk("R6 second half", v, 32'hC000_0008);
        rd(3'd4, v); chk("R6 new ptr", v, 32'h0000_0400);
        pulse_ack(3);
        rd(3'd1, v); chk("R6 new count half", v, 32'hD000_0008);
        rd(3'd4, v); chk("R6 new half ptr", v, 32'h0000_040C);
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h0);
        wr(3'd1, 32'h4000_0000);

        // R8: peripheral wrap
        wr(3'd7, 32'h0001_0000);
        wr(3'd6, 32'h7000_0040);
        wr(3'd0, 32'h8800_0010);
        xfer_ack = 1'b1; wait_idle(); xfer_ack = 1'b0;
        rd(3'd6, v); chk("R8 one-word window", v, 32'h7000_0040);
        wr(3'd7, 32'h0003_0000);
        wr(3'd6, 32'h8000_000C);
        wr(3'd0, 32'h8800_0004);
        xfer_ack = 1'b1; wait_idle(); xfer_ack = 1'b0;
        rd(3'd6, v); chk("R8 four-word window", v, 32'h8000_0004);

        done = 1;
        summary();
    end
endmodule